// File: doc/BRIEF.md
# Privileged Control and Debug Register Unit

This block owns the control-register and debug-register file of a small 32-bit processor core. The execute stage hands it one privileged request at a time: a read or write of a control register, a read or write of a debug register, or a clear of the task-switched flag. Each request carries a 3-bit architectural index, 32 bits of write data and the current privilege level. One cycle later the block returns either a completion strobe with read data, or exactly one fault: general protection or undefined opcode. The core's trap logic raises the fault. Decoding the instruction and delivering the exception are done elsewhere.

Control indices are sparse. Only indices 0, 2 and 3 exist, and they are packed into three storage slots. Debug indices 6 and 7 are aliases of slots 4 and 5, so six physical debug registers exist. Writes to the main control register are screened against two illegal bit pairings. A global-detect bit in the debug control slot locks out all further debug-register traffic.

The response path is a three-state machine. `RS_IDLE` means there is no response. `RS_DONE` means the previous request completed. `RS_FAULT` means the previous request was refused. A valid request whose checks all pass takes the transition `go_done` into `RS_DONE`. A valid request that fails a check takes `go_fault` into `RS_FAULT`. A cycle with no request takes `go_idle` back to `RS_IDLE`. Every state can reach every state, so back-to-back requests are accepted every cycle.

Top module: `priv_reg_unit`

## Requirements
- R1: After reset, `rsp_done` is 0, `rsp_fault` is 2'b00 and `rsp_rdata` is 0. All control registers and debug slots read as 0, except debug slot 4, which reads 0xFFFF0FF0.
- R2: Operation codes are 0 (read control), 1 (write control), 2 (read debug), 3 (write debug) and 4 (clear task-switched). In the cycle after a valid request, exactly one of `rsp_done` and a fault bit is 1. After a cycle with no request, all response outputs are 0.
- R3: `rsp_fault` bit 0 means general protection. Any request made with a privilege level other than 0 gets general protection and changes no register. This check comes before every other check.
- R4: `rsp_fault` bit 1 means undefined opcode. It is raised at privilege 0 for a control access to index 1, 4, 5, 6 or 7, and for operation codes 5 to 7. The request changes no register.
- R5: Control indices 2 and 3 have their own storage, separate from index 0. A read returns the last value written to that index.
- R6: A write to control index 0 that has bit 31 set and bit 0 clear gets general protection and leaves the register unchanged.
- R7: A write to control index 0 that has bit 29 set and bit 30 clear gets general protection and leaves the register unchanged.
- R8: Debug indices 6 and 7 read and write the same storage as indices 4 and 5.
- R9: While bit 13 of debug slot 5 is 1, every debug read or write at privilege 0 gets general protection and changes nothing. Control accesses are unaffected.
- R10: A write to debug slot 4 stores the data OR 0xFFFF0FF0. A write to debug slot 5 stores the data AND NOT 0x0000DC00.
- R11: Clear task-switched at privilege 0 clears bit 3 of control register 0 and leaves every other bit unchanged.
- R12: `rsp_rdata` carries the register value only after a completed read. It is 0 after writes, clears and faults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 3 | Operation code (see R2) |
| req_idx | input | 3 | Architectural register index |
| req_wdata | input | 32 | Write data |
| req_cpl | input | 2 | Current privilege level |
| rsp_done | output | 1 | The previous request completed |
| rsp_fault | output | 2 | One-hot fault: bit 0 general protection, bit 1 undefined opcode |
| rsp_rdata | output | 32 | Read result of the previous request |

## Verification
The assertions assume that the execute stage presents at most one request per cycle. They also assume that `req_op`, `req_idx`, `req_cpl` and `req_wdata` are stable and meaningful whenever `req_valid` is high. The register-content properties assume that the file starts from the reset pattern. Stimulus holds every field for a full clock around the edge, and it drives the fields only while a request is valid. Stimulus deliberately reaches the unused operation codes and the locked debug state. A second reset is used only between sections, so that the global-detect lock can be released.

// File: rtl/priv_reg_pkg.sv
package priv_reg_pkg;

    localparam int XLEN = 32;
    localparam int IDX_W = 3;
    localparam int CPL_W = 2;

    // control register bit positions
    localparam int CR0_PE = 0;
    localparam int CR0_TS = 3;
    localparam int CR0_NW = 29;
    localparam int CR0_CD = 30;
    localparam int CR0_PG = 31;

    // debug storage layout
    localparam int NUM_CR_SLOTS = 3;
    localparam int NUM_DR_SLOTS = 6;
    localparam int DR_STAT_SLOT = 4;
    localparam int DR_CTRL_SLOT = 5;
    localparam int DR_ALIAS_BASE = 6;
    localparam int DR_ALIAS_SHIFT = 2;
    localparam int DCTL_GD = 13;

    localparam logic [XLEN-1:0] DSTAT_ONES = 32'hFFFF_0FF0;
    localparam logic [XLEN-1:0] DCTL_ZEROS = 32'h0000_DC00;

    typedef enum logic [2:0] {
        OP_RD_CR  = 3'd0,
        OP_WR_CR  = 3'd1,
        OP_RD_DR  = 3'd2,
        OP_WR_DR  = 3'd3,
        OP_CLR_TS = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_GP   = 2'b01,
        FLT_UD   = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_DONE  = 2'd1,
        RS_FAULT = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/priv_access_check.sv
module priv_access_check
    import priv_reg_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int PW = CPL_W,
    parameter int CR_SW = $clog2(NUM_CR_SLOTS),
    parameter int DR_SW = $clog2(NUM_DR_SLOTS)
) (
    input  logic             valid,
    input  logic [2:0]       op,
    input  logic [IW-1:0]    idx,
    input  logic [PW-1:0]    cpl,
    input  logic             wr_pg,
    input  logic             wr_pe,
    input  logic             wr_nw,
    input  logic             wr_cd,
    input  logic             gd_lock,
    output fault_e           fault,
    output logic [CR_SW-1:0] cr_slot,
    output logic [DR_SW-1:0] dr_slot,
    output logic             cr_we,
    output logic             dr_we,
    output logic             clr_ts,
    output logic             cr_rd,
    output logic             dr_rd
);

    logic priv_ok;
    logic cr_idx_ok;
    logic cr0_bad;
    logic pass;
    op_e  op_q;

    assign op_q      = op_e'(op);
    assign priv_ok   = (cpl == '0);
    assign cr_idx_ok = (idx == IW'(0)) || (idx == IW'(2)) || (idx == IW'(3));
    assign cr0_bad   = (wr_pg && !wr_pe) || (wr_nw && !wr_cd);

    // sparse control index to packed slot
    assign cr_slot = (idx == IW'(0)) ? '0 : CR_SW'(idx - IW'(1));

    // debug alias resolution
    assign dr_slot = (idx >= IW'(DR_ALIAS_BASE)) ? DR_SW'(idx - IW'(DR_ALIAS_SHIFT))
                                                 : DR_SW'(idx);

    always_comb begin
        fault = FLT_NONE;
        if (!priv_ok) begin
            fault = FLT_GP;
        end else begin
            unique case (op_q)
                OP_RD_CR: begin
                    if (!cr_idx_ok) fault = FLT_UD;
                end
                OP_WR_CR: begin
                    if (!cr_idx_ok) fault = FLT_UD;
                    else if ((idx == IW'(0)) && cr0_bad) fault = FLT_GP;
                end
                OP_RD_DR, OP_WR_DR: begin
                    if (gd_lock) fault = FLT_GP;
                end
                OP_CLR_TS: fault = FLT_NONE;
                default: fault = FLT_UD;
            endcase
        end
    end

    assign pass   = valid && (fault == FLT_NONE);
    assign cr_we  = pass && (op_q == OP_WR_CR);
    assign dr_we  = pass && (op_q == OP_WR_DR);
    assign clr_ts = pass && (op_q == OP_CLR_TS);
    assign cr_rd  = pass && (op_q == OP_RD_CR);
    assign dr_rd  = pass && (op_q == OP_RD_DR);

    // R4
    always_comb begin
        ud_idx_chk: assert (!(cr_we || cr_rd) || cr_idx_ok);
    end

    // R3
    always_comb begin
        priv_gate_chk: assert (!(cr_we || dr_we || clr_ts) || priv_ok);
    end

endmodule

// File: rtl/priv_ctrl_regs.sv
module priv_ctrl_regs
    import priv_reg_pkg::*;
#(
    parameter int W = XLEN,
    parameter int NSLOT = NUM_CR_SLOTS,
    parameter int SW = $clog2(NUM_CR_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] slot,
    input  logic [W-1:0]  wdata,
    input  logic          clr_ts,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cr_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [W-1:0] q;
        if (g == 0) begin : g_main
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we && (slot == SW'(g))) begin
                    q <= wdata;
                end else if (clr_ts) begin
                    q[CR0_TS] <= 1'b0;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we && (slot == SW'(g))) begin
                    q <= wdata;
                end
            end
        end
        assign cr_q[g] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (slot == SW'(i)) rdata = cr_q[i];
        end
    end

    // R6
    paging_combo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cr_q[0][CR0_PG] && !cr_q[0][CR0_PE]));

    // R7
    cache_combo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cr_q[0][CR0_NW] && !cr_q[0][CR0_CD]));

    // R11
    ts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ts |=> !cr_q[0][CR0_TS]);

    // R11
    ts_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ts |=> (cr_q[0] | (W'(1) << CR0_TS)) == ($past(cr_q[0]) | (W'(1) << CR0_TS)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !clr_ts) |=> $stable(cr_q[0]) && $stable(cr_q[1]) && $stable(cr_q[2]));

endmodule

// File: rtl/priv_dbg_regs.sv
module priv_dbg_regs
    import priv_reg_pkg::*;
#(
    parameter int W = XLEN,
    parameter int NSLOT = NUM_DR_SLOTS,
    parameter int SW = $clog2(NUM_DR_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] slot,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          gd_lock
);

    logic [W-1:0] dr_q [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [W-1:0] RST_VAL = (g == DR_STAT_SLOT) ? DSTAT_ONES : '0;
        logic [W-1:0] q;
        logic [W-1:0] shaped;
        if (g == DR_STAT_SLOT) begin : g_stat
            assign shaped = wdata | DSTAT_ONES;
        end else if (g == DR_CTRL_SLOT) begin : g_ctrl
            assign shaped = wdata & ~DCTL_ZEROS;
        end else begin : g_addr
            assign shaped = wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= RST_VAL;
            end else if (we && (slot == SW'(g))) begin
                q <= shaped;
            end
        end
        assign dr_q[g] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (slot == SW'(i)) rdata = dr_q[i];
        end
    end

    assign gd_lock = dr_q[DR_CTRL_SLOT][DCTL_GD];

    // R10
    stat_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_q[DR_STAT_SLOT] & DSTAT_ONES) == DSTAT_ONES);

    // R10
    ctrl_zeros_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_q[DR_CTRL_SLOT] & DCTL_ZEROS) == '0);

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gd_lock |=> gd_lock);

    // R9
    dbg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(dr_q[DR_STAT_SLOT]) && $stable(dr_q[DR_CTRL_SLOT]) && $stable(dr_q[0]));

endmodule

// File: rtl/priv_reg_unit.sv
module priv_reg_unit
    import priv_reg_pkg::*;
#(
    parameter int W = XLEN,
    parameter int IW = IDX_W,
    parameter int PW = CPL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [IW-1:0] req_idx,
    input  logic [W-1:0]  req_wdata,
    input  logic [PW-1:0] req_cpl,
    output logic          rsp_done,
    output logic [1:0]    rsp_fault,
    output logic [W-1:0]  rsp_rdata
);

    localparam int CR_SW = $clog2(NUM_CR_SLOTS);
    localparam int DR_SW = $clog2(NUM_DR_SLOTS);

    fault_e           fault;
    logic [CR_SW-1:0] cr_slot;
    logic [DR_SW-1:0] dr_slot;
    logic             cr_we, dr_we, clr_ts, cr_rd, dr_rd;
    logic             gd_lock;
    logic [W-1:0]     cr_rdata, dr_rdata;

    rsp_state_e       state_q, state_d;
    fault_e           flt_q;
    logic [W-1:0]     rdata_q;

    priv_access_check #(.IW(IW), .PW(PW), .CR_SW(CR_SW), .DR_SW(DR_SW)) u_check (
        .valid   (req_valid),
        .op      (req_op),
        .idx     (req_idx),
        .cpl     (req_cpl),
        .wr_pg   (req_wdata[CR0_PG]),
        .wr_pe   (req_wdata[CR0_PE]),
        .wr_nw   (req_wdata[CR0_NW]),
        .wr_cd   (req_wdata[CR0_CD]),
        .gd_lock (gd_lock),
        .fault   (fault),
        .cr_slot (cr_slot),
        .dr_slot (dr_slot),
        .cr_we   (cr_we),
        .dr_we   (dr_we),
        .clr_ts  (clr_ts),
        .cr_rd   (cr_rd),
        .dr_rd   (dr_rd)
    );

    priv_ctrl_regs #(.W(W), .NSLOT(NUM_CR_SLOTS), .SW(CR_SW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cr_we),
        .slot   (cr_slot),
        .wdata  (req_wdata),
        .clr_ts (clr_ts),
        .rdata  (cr_rdata)
    );

    priv_dbg_regs #(.W(W), .NSLOT(NUM_DR_SLOTS), .SW(DR_SW)) u_dbg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (dr_we),
        .slot    (dr_slot),
        .wdata   (req_wdata),
        .rdata   (dr_rdata),
        .gd_lock (gd_lock)
    );

    // next-state: go_done / go_fault / go_idle
    always_comb begin
        if (!req_valid)               state_d = RS_IDLE;
        else if (fault == FLT_NONE)   state_d = RS_DONE;
        else                          state_d = RS_FAULT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q   <= FLT_NONE;
            rdata_q <= '0;
        end else begin
            flt_q   <= req_valid ? fault : FLT_NONE;
            rdata_q <= cr_rd ? cr_rdata : (dr_rd ? dr_rdata : '0);
        end
    end

    always_comb begin
        rsp_done  = 1'b0;
        rsp_fault = 2'b00;
        rsp_rdata = '0;
        unique case (state_q)
            RS_IDLE:  ;
            RS_DONE: begin
                rsp_done  = 1'b1;
                rsp_rdata = rdata_q;
            end
            RS_FAULT: rsp_fault = flt_q;
            default:  ;
        endcase
    end

    // R2
    one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_done != (rsp_fault != 2'b00)));

    // R2
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_done && (rsp_fault == 2'b00));

    // R2
    fault_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_fault));

    // R3
    priv_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_cpl != '0)) |=> (rsp_fault == 2'b01));

    // R12
    rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> (rsp_rdata == '0));

endmodule

// File: tb/priv_reg_unit_tb.sv
module priv_reg_unit_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] RC = 3'd0, WC = 3'd1, RD = 3'd2, WD = 3'd3, CT = 3'd4;
    localparam logic [1:0] FN = 2'b00, GP = 2'b01, UD = 2'b10;

    // fields: req[77:74] op[73:71] idx[70:68] cpl[67:66] wdata[65:34] flt[33:32] rdata[31:0]
    localparam int NV = 47;
    localparam logic [77:0] VEC [NV] = '{
        {4'd1,  RC, 3'd0, 2'd0, 32'h0,          FN, 32'h0},          // R1 cr0 reset
        {4'd1,  RD, 3'd6, 2'd0, 32'h0,          FN, 32'hFFFF0FF0},   // R1 status reset
        {4'd12, WC, 3'd0, 2'd0, 32'h00000009,   FN, 32'h0},          // R12 write data 0
        {4'd5,  RC, 3'd0, 2'd0, 32'h0,          FN, 32'h00000009},
        {4'd6,  WC, 3'd0, 2'd0, 32'h80000000,   GP, 32'h0},          // R6
        {4'd6,  RC, 3'd0, 2'd0, 32'h0,          FN, 32'h00000009},
        {4'd7,  WC, 3'd0, 2'd0, 32'h20000001,   GP, 32'h0},          // R7
        {4'd7,  RC, 3'd0, 2'd0, 32'h0,          FN, 32'h00000009},
        {4'd7,  WC, 3'd0, 2'd0, 32'h60000001,   FN, 32'h0},
        {4'd7,  RC, 3'd0, 2'd0, 32'h0,          FN, 32'h60000001},
        {4'd3,  WC, 3'd0, 2'd3, 32'h80000009,   GP, 32'h0},          // R3
        {4'd3,  RC, 3'd0, 2'd0, 32'h0,          FN, 32'h60000001},
        {4'd5,  WC, 3'd2, 2'd0, 32'h12345678,   FN, 32'h0},          // R5
        {4'd5,  WC, 3'd3, 2'd0, 32'hCAFEF00D,   FN, 32'h0},
        {4'd5,  RC, 3'd2, 2'd0, 32'h0,          FN, 32'h12345678},
        {4'd5,  RC, 3'd3, 2'd0, 32'h0,          FN, 32'hCAFEF00D},
        {4'd5,  RC, 3'd0, 2'd0, 32'h0,          FN, 32'h60000001},
        {4'd4,  RC, 3'd1, 2'd0, 32'h0,          UD, 32'h0},          // R4
        {4'd4,  RC, 3'd4, 2'd0, 32'h0,          UD, 32'h0},
        {4'd3,  RC, 3'd5, 2'd1, 32'h0,          GP, 32'h0},          // R3 priority
        {4'd4,  WC, 3'd7, 2'd0, 32'h00000001,   UD, 32'h0},
        {4'd4,  RC, 3'd3, 2'd0, 32'h0,          FN, 32'hCAFEF00D},
        {4'd4,  3'd5, 3'd0, 2'd0, 32'h0,        UD, 32'h0},
        {4'd3,  3'd6, 3'd0, 2'd2, 32'h0,        GP, 32'h0},
        {4'd11, WC, 3'd0, 2'd0, 32'h80000009,   FN, 32'h0},          // R11
        {4'd11, CT, 3'd0, 2'd2, 32'h0,          GP, 32'h0},
        {4'd11, RC, 3'd0, 2'd0, 32'h0,          FN, 32'h80000009},
        {4'd11, CT, 3'd0, 2'd0, 32'h0,          FN, 32'h0},
        {4'd11, RC, 3'd0, 2'd0, 32'h0,          FN, 32'h80000001},
        {4'd8,  WD, 3'd0, 2'd0, 32'hAAAA5555,   FN, 32'h0},          // R8
        {4'd8,  RD, 3'd0, 2'd0, 32'h0,          FN, 32'hAAAA5555},
        {4'd10, WD, 3'd4, 2'd0, 32'h0,          FN, 32'h0},          // R10
        {4'd10, RD, 3'd6, 2'd0, 32'h0,          FN, 32'hFFFF0FF0},
        {4'd8,  WD, 3'd6, 2'd0, 32'h0000000F,   FN, 32'h0},
        {4'd8,  RD, 3'd4, 2'd0, 32'h0,          FN, 32'hFFFF0FFF},
        {4'd8,  WD, 3'd7, 2'd0, 32'h00000303,   FN, 32'h0},
        {4'd8,  RD, 3'd5, 2'd0, 32'h0,          FN, 32'h00000303},
        {4'd10, WD, 3'd5, 2'd0, 32'h0000DCFF,   FN, 32'h0},
        {4'd10, RD, 3'd7, 2'd0, 32'h0,          FN, 32'h000000FF},
        {4'd3,  WD, 3'd5, 2'd1, 32'h00002000,   GP, 32'h0},
        {4'd9,  RD, 3'd5, 2'd0, 32'h0,          FN, 32'h000000FF},   // R9
        {4'd9,  WD, 3'd5, 2'd0, 32'h0000FFFF,   FN, 32'h0},
        {4'd9,  RD, 3'd5, 2'd0, 32'h0,          GP, 32'h0},
        {4'd9,  RD, 3'd0, 2'd0, 32'h0,          GP, 32'h0},
        {4'd9,  WD, 3'd1, 2'd0, 32'h0,          GP, 32'h0},
        {4'd9,  RC, 3'd0, 2'd0, 32'h0,          FN, 32'h80000001},
        {4'd9,  RC, 3'd2, 2'd0, 32'h0,          FN, 32'h12345678}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [2:0]  req_idx = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_cpl = '0;
    logic        rsp_done;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_reg_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_idx   (req_idx),
        .req_wdata (req_wdata),
        .req_cpl   (req_cpl),
        .rsp_done  (rsp_done),
        .rsp_fault (rsp_fault),
        .rsp_rdata (rsp_rdata)
    );

    task automatic expect_rsp(input int rq, input logic ed, input logic [1:0] ef,
                              input logic [31:0] er, input string tag);
        checks++;
        if (rsp_done !== ed || rsp_fault !== ef || rsp_rdata !== er) begin
            errors++;
            $display("FAIL R%0d %s: done=%0b fault=%b rdata=%h expected done=%0b fault=%b rdata=%h",
                     rq, tag, rsp_done, rsp_fault, rsp_rdata, ed, ef, er);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [2:0] idx, input logic [1:0] cpl,
                         input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_idx   = idx;
        req_cpl   = cpl;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        req_op    = '0;
        req_idx   = '0;
        req_cpl   = '0;
        req_wdata = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog expired: done=%0b expected completion", rsp_done);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state of the outputs
        expect_rsp(1, 1'b0, 2'b00, 32'h0, "reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        // R2 no request gives no response
        expect_rsp(2, 1'b0, 2'b00, 32'h0, "idle cycle");

        for (int v = 0; v < NV; v++) begin
            do_op(VEC[v][73:71], VEC[v][70:68], VEC[v][67:66], VEC[v][65:34]);
            expect_rsp(int'(VEC[v][77:74]), VEC[v][33:32] == 2'b00, VEC[v][33:32],
                       VEC[v][31:0], $sformatf("vector %0d", v));
        end

        // R2 response drops back after the last request
        @(negedge clk);
        expect_rsp(2, 1'b0, 2'b00, 32'h0, "idle after burst");

        // R1 second reset releases the lock and restores patterns
        rst_n = 1'b0;
        @(negedge clk);
        expect_rsp(1, 1'b0, 2'b00, 32'h0, "outputs in reset");
        rst_n = 1'b1;
        do_op(RD, 3'd5, 2'd0, 32'h0);
        expect_rsp(1, 1'b1, 2'b00, 32'h0, "debug ctrl after reset");
        do_op(RD, 3'd4, 2'd0, 32'h0);
        expect_rsp(1, 1'b1, 2'b00, 32'hFFFF0FF0, "debug status after reset");
        do_op(RC, 3'd3, 2'd0, 32'h0);
        expect_rsp(1, 1'b1, 2'b00, 32'h0, "cr3 after reset");

        // R6 both illegal pairings at once, then a legal neighbour
        do_op(WC, 3'd0, 2'd0, 32'hA0000000);
        expect_rsp(6, 1'b0, 2'b01, 32'h0, "pg and nw without pe/cd");
        do_op(WC, 3'd0, 2'd0, 32'hE0000001);
        expect_rsp(7, 1'b1, 2'b00, 32'h0, "all of pg pe nw cd");
        do_op(RC, 3'd0, 2'd0, 32'h0);
        expect_rsp(7, 1'b1, 2'b00, 32'hE0000001, "cr0 readback");

        // R11 clear when already clear keeps everything
        do_op(CT, 3'd0, 2'd0, 32'h0);
        expect_rsp(11, 1'b1, 2'b00, 32'h0, "clear ts done");
        do_op(RC, 3'd0, 2'd0, 32'h0);
        expect_rsp(11, 1'b1, 2'b00, 32'hE0000001, "clear ts idempotent");

        // R4 undefined op 7 at privilege 0
        do_op(3'd7, 3'd2, 2'd0, 32'h0);
        expect_rsp(4, 1'b0, 2'b10, 32'h0, "op 7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule